// File: doc/BRIEF.md
# Fan PWM Group with Edge-Position Duty Control

This block drives a small group of fan PWM outputs from one shared time base. A prescaler divides the system clock by a linear low divisor and by a power-of-two high divisor. Each prescaler tick advances an 8-bit period counter, which wraps after a programmed period unit. Every output port compares that counter against its own pair of 8-bit edge positions. One position sets where the output goes high and the other sets where it goes low. Either ordering is allowed, so a pulse may straddle the period wrap.

Software programs the block through a plain single-cycle write port. A control word holds the global enable, the per-port enables and a per-port clock-type select. A clock word holds the prescaler and period settings. Each duty word holds the edge positions for one pair of ports. New edge positions are taken up only when a period ends, so an update in the middle of a pulse never cuts it short or stretches it. Only clock type 0 exists in this block. A port that selects any other type is held low.

Top module: `fanpwm_group`

## Requirements
- R1: After reset all outputs are low, and they stay low until software enables a port.
- R2: The clock word (address 1) holds the low divisor L in bits 3:0, the high exponent H in bits 7:4 and the period unit U in bits 15:8. The output period is L·2^H·(U+1) clocks, and L = 0 acts as 1.
- R3: Duty word k (address 2+k) serves port 2k through bits 15:0 and port 2k+1 through bits 31:16. Within each half, the high-going position is in the low byte and the low-going position is in the high byte.
- R4: When the high-going position R is less than the low-going position F, the output is high for (F−R)·L·2^H clocks of each period.
- R5: When R is greater than F, the pulse wraps around the period end. The output is high for (U+1−R+F)·L·2^H clocks.
- R6: When R equals F, the output stays high for the whole period (full on).
- R7: Control word (address 0) bit 8+p enables port p. A port whose enable bit is clear holds its output low, while the other ports keep running.
- R8: Control word bit 0 is the global enable. While it is clear, every output is low and the time base is held at count zero.
- R9: The clock-type select of port p takes its low bit from control bit 12+p and its high bit from control bit 4+p. Any nonzero select holds that port low.
- R10: Edge positions written during a period take effect only from the next period boundary. A pulse already in progress keeps its old width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| pwm_out | output | NUM_PORTS | Fan PWM outputs |

## Verification
The bench builds the block with its defaults: four ports and a 3-bit address. With four ports, both duty words and both halves of each word are in use. The control-word bit positions for every port enable and type select are also exercised. The bench programs very small divisors, so a full period lasts 10 to 60 clocks. This makes wrap-around pulses, full-on operation, a zero low divisor and a mid-pulse edge update all cheap to observe.

// File: rtl/fanpwm_pkg.sv
// Shared types and register layout of the fan PWM group.
// Assumes at most four ports, because the control-word bit fields are laid out for four.
package fanpwm_pkg;
    localparam int MAX_PORTS     = 4;
    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_CLKCFG   = 1;
    localparam int ADDR_DUTY0    = 2;
    localparam int GLB_EN_BIT    = 0;
    localparam int PORT_EN_BASE  = 8;
    localparam int TSEL_LO_BASE  = 12;
    localparam int TSEL_HI_BASE  = 4;
    localparam int HEXP_W        = 4;
    localparam int LDIV_W        = 4;
    localparam int PRE_W         = LDIV_W + (1 << HEXP_W) - 1;

    // Prescaler and period settings; field order fixes the bit positions.
    typedef struct packed {
        logic [7:0]        unit;
        logic [HEXP_W-1:0] hexp;
        logic [LDIV_W-1:0] ldiv;
    } clk_cfg_t;

    // Edge positions of one port; the high-going position sits in the low byte.
    typedef struct packed {
        logic [7:0] fall;
        logic [7:0] rise;
    } edges_t;
endpackage

// File: rtl/fanpwm_regs.sv
// Write-only register file of the fan PWM group.
// Decodes the control word, the clock word and one duty word per port pair.
// Assumes NUM_PORTS is even and no more than MAX_PORTS.
module fanpwm_regs
    import fanpwm_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [31:0]                 wr_data,
    output logic                        glb_en_o,
    output clk_cfg_t                    cfg_o,
    output logic [NUM_PORTS-1:0]        port_en_o,
    output logic [NUM_PORTS-1:0][1:0]   tsel_o,
    output edges_t [NUM_PORTS-1:0]      edges_o
);
    localparam int NUM_PAIRS = NUM_PORTS / 2;

    // Control word: global enable, per-port enables and type selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_en_o  <= 1'b0;
            port_en_o <= '0;
            tsel_o    <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(ADDR_CTRL)) begin
            glb_en_o <= wr_data[GLB_EN_BIT];
            for (int p = 0; p < NUM_PORTS; p++) begin
                port_en_o[p] <= wr_data[PORT_EN_BASE + p];
                tsel_o[p]    <= {wr_data[TSEL_HI_BASE + p], wr_data[TSEL_LO_BASE + p]};
            end
        end
    end

    // Clock word: low divisor, high exponent, period unit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_o <= '0;
        else if (wr_en && wr_addr == ADDR_W'(ADDR_CLKCFG))
            cfg_o <= wr_data[15:0];
    end

    generate
        for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
            // Duty word k: even port in the low half, odd port in the high half.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    edges_o[2*k]   <= '0;
                    edges_o[2*k+1] <= '0;
                end else if (wr_en && wr_addr == ADDR_W'(ADDR_DUTY0 + k)) begin
                    edges_o[2*k]   <= wr_data[15:0];
                    edges_o[2*k+1] <= wr_data[31:16];
                end
            end
        end
    endgenerate

    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(ADDR_CLKCFG)) |=> (cfg_o == $past(wr_data[15:0])));
endmodule

// File: rtl/fanpwm_timebase.sv
// Shared time base of the fan PWM group.
// Ticks every L*2^H clocks (L = 0 acts as 1) and steps a period counter that wraps after the unit value.
// Assumes configuration writes may arrive at any time; both compares use >= so that a shrunk setting recovers.
module fanpwm_timebase
    import fanpwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      glb_en_i,
    input  clk_cfg_t  cfg_i,
    output logic [7:0] count_o,
    output logic      load_o
);
    logic [PRE_W-1:0]  pre_q;
    logic [PRE_W-1:0]  terminal;
    logic [LDIV_W-1:0] ldiv_eff;
    logic              tick;
    logic              wrap;

    // Terminal prescaler value for the programmed divisors.
    always_comb begin
        ldiv_eff = (cfg_i.ldiv == '0) ? LDIV_W'(1) : cfg_i.ldiv;
        terminal = (PRE_W'(ldiv_eff) << cfg_i.hexp) - PRE_W'(1);
        tick     = glb_en_i && (pre_q >= terminal);
        wrap     = tick && (count_o >= cfg_i.unit);
    end

    // Prescaler counter, cleared while the group is globally disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !glb_en_i || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + PRE_W'(1);
    end

    // Period counter, advancing once per prescaler tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !glb_en_i)
            count_o <= '0;
        else if (tick)
            count_o <= wrap ? 8'd0 : count_o + 8'd1;
    end

    assign load_o = wrap || !glb_en_i;

    assert_idle_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en_i |=> (count_o == 8'd0));
endmodule

// File: rtl/fanpwm_channel.sv
// One fan PWM output.
// Shadows its edge positions at each period boundary and drives high inside the window from R to F, wrapping past the period end.
// Assumes run_i already folds in the global enable, the port enable and the type check.
module fanpwm_channel
    import fanpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       load_i,
    input  edges_t     edges_i,
    input  logic [7:0] count_i,
    output logic       pwm_o
);
    edges_t shadow_q;
    logic   in_window;

    // Takes up new edge positions only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (load_i)
            shadow_q <= edges_i;
    end

    // Window test for both orderings and for equal positions.
    always_comb begin
        if (shadow_q.rise == shadow_q.fall)
            in_window = 1'b1;
        else if (shadow_q.rise < shadow_q.fall)
            in_window = (count_i >= shadow_q.rise) && (count_i < shadow_q.fall);
        else
            in_window = (count_i >= shadow_q.rise) || (count_i < shadow_q.fall);
    end

    // Registered output, low whenever the port may not run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwm_o <= 1'b0;
        else
            pwm_o <= run_i && in_window;
    end

    assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(shadow_q));
    assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !pwm_o);
    assert_full_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && shadow_q.rise == shadow_q.fall) |=> pwm_o);
endmodule

// File: rtl/fanpwm_group.sv
// Top of the fan PWM group: register file, one shared time base, and one channel per port.
// Assumes NUM_PORTS is even and at most four. Only clock type 0 is implemented.
module fanpwm_group
    import fanpwm_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [31:0]          wr_data,
    output logic [NUM_PORTS-1:0] pwm_out
);
    logic                       glb_en;
    clk_cfg_t                   cfg;
    logic [NUM_PORTS-1:0]       port_en;
    logic [NUM_PORTS-1:0][1:0]  tsel;
    edges_t [NUM_PORTS-1:0]     edges;
    logic [7:0]                 count;
    logic                       load;

    fanpwm_regs #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .glb_en_o(glb_en), .cfg_o(cfg), .port_en_o(port_en), .tsel_o(tsel), .edges_o(edges)
    );

    fanpwm_timebase timebase_i (
        .clk(clk), .rst_n(rst_n), .glb_en_i(glb_en), .cfg_i(cfg),
        .count_o(count), .load_o(load)
    );

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            logic run;
            assign run = glb_en && port_en[p] && (tsel[p] == 2'b00);
            fanpwm_channel chan_i (
                .clk(clk), .rst_n(rst_n), .run_i(run), .load_i(load),
                .edges_i(edges[p]), .count_i(count), .pwm_o(pwm_out[p])
            );
        end
    endgenerate

    assert_global_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> (pwm_out == '0));
    assert_type_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tsel[0] != 2'b00) |=> !pwm_out[0]);
endmodule

// File: tb/fanpwm_group_tb.sv
// Directed bench for the fan PWM group. It measures pulse widths and periods at the outputs.
module fanpwm_group_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int AW = 3;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [NP-1:0] pwm_out;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    fanpwm_group #(.NUM_PORTS(NP), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic reg_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Waits for a rising output, then counts the high and low spans; returns -1 on timeout.
    task automatic measure(input int p, output int hi, output int per);
        int t = 0;
        int lo = 0;
        hi = 0;
        @(negedge clk);
        while (pwm_out[p] && t < 2000) begin @(negedge clk); t++; end
        while (!pwm_out[p] && t < 2000) begin @(negedge clk); t++; end
        while (pwm_out[p] && t < 2000) begin @(negedge clk); t++; hi++; end
        while (!pwm_out[p] && t < 2000) begin @(negedge clk); t++; lo++; end
        per = (t >= 2000) ? -1 : hi + lo;
        if (t >= 2000) hi = -1;
    endtask

    // Counts high samples of port p over n cycles.
    task automatic count_high(input int p, input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[p]) highs++;
        end
    endtask

    task automatic t_reset;
        int h;
        check("R1 outputs low after reset", int'(pwm_out), 0);
        count_high(0, 60, h);
        check("R1 port0 stays low", h, 0);
    endtask

    task automatic t_windows;
        int hi, per, h;
        reg_write(1, 32'h0000_0912);                          // L=2 H=1 U=9 -> 40 clocks
        reg_write(2, {8'd2, 8'd8, 8'd7, 8'd2});              // p0 R2 F7, p1 R8 F2
        reg_write(3, {8'd3, 8'd0, 8'd5, 8'd5});              // p2 R=F, p3 R0 F3
        reg_write(0, 32'h0000_0F01);
        measure(0, hi, per); measure(0, hi, per);
        check("R2 period 40", per, 40);
        check("R4 R<F width, R3 low half", hi, 20);
        measure(1, hi, per);
        check("R5 wrapped width, R3 high half", hi, 16);
        measure(3, hi, per);
        check("R3 second duty word width", hi, 12);
        count_high(2, 200, h);
        check("R6 full on", h, 200);
    endtask

    task automatic t_freq;
        int hi, per;
        reg_write(2, {8'd2, 8'd8, 8'd3, 8'd1});              // p0 R1 F3
        reg_write(1, 32'h0000_0423);                          // L=3 H=2 U=4 -> 60 clocks
        measure(0, hi, per); measure(0, hi, per);
        check("R2 period L3 H2 U4", per, 60);
        check("R2 width scales with divisor", hi, 24);
        reg_write(1, 32'h0000_0900);                          // L=0 acts as 1 -> 10 clocks
        measure(0, hi, per); measure(0, hi, per);
        check("R2 zero low divisor period", per, 10);
        check("R2 zero low divisor width", hi, 2);
        reg_write(1, 32'h0000_0912);
        reg_write(2, {8'd2, 8'd8, 8'd7, 8'd2});
    endtask

    task automatic t_enables;
        int hi, per, h;
        reg_write(0, 32'h0000_0D01);                          // port1 enable clear
        count_high(1, 200, h);
        check("R7 disabled port low", h, 0);
        measure(0, hi, per);
        check("R7 other port runs", per, 40);
        reg_write(0, 32'h0000_0F01 | (32'h1 << 5));           // port1 type high bit
        count_high(1, 200, h);
        check("R9 type high bit blocks", h, 0);
        reg_write(0, 32'h0000_0F01 | (32'h1 << 13));          // port1 type low bit
        count_high(1, 200, h);
        check("R9 type low bit blocks", h, 0);
        measure(0, hi, per);
        check("R9 port0 unaffected", per, 40);
        reg_write(0, 32'h0000_0F00);                          // global enable clear
        repeat (3) @(negedge clk);
        count_high(2, 200, h);
        check("R8 global off holds full-on port low", h, 0);
        reg_write(0, 32'h0000_0F01);
        measure(0, hi, per); measure(0, hi, per);
        check("R8 restart period", per, 40);
    endtask

    task automatic t_update;
        int hi, per, t;
        reg_write(2, {8'd2, 8'd8, 8'd3, 8'd0});              // p0 R0 F3 -> 12
        measure(0, hi, per); measure(0, hi, per);
        check("R10 baseline width", hi, 12);
        t = 0;
        @(negedge clk);
        while (pwm_out[0] && t < 2000) begin @(negedge clk); t++; end
        while (!pwm_out[0] && t < 2000) begin @(negedge clk); t++; end
        hi = 0;
        while (pwm_out[0] && t < 2000) begin
            if (hi == 2) begin
                wr_en = 1'b1; wr_addr = AW'(2); wr_data = {8'd2, 8'd8, 8'd8, 8'd0};
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk); t++; hi++;
        end
        wr_en = 1'b0;
        check("R10 pulse in progress keeps old width", hi, 12);
        measure(0, hi, per);
        check("R10 new width next period", hi, 32);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_windows();
        t_freq();
        t_enables();
        t_update();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule